// File: doc/BRIEF.md
# Quadratic Residue Complex Mapper

This block moves a Gaussian integer, given as a real part and an imaginary part each held modulo m, into two channels that share nothing. It evaluates the first-degree polynomial real + imag·x at both square roots of −1 in the ring of integers modulo m. Those roots are r and m − r. In the channel domain a complex product becomes two separate modular products, one per channel. The same block also runs the other way: from the two channel values it recovers the real and imaginary parts. A mode input selects the direction for each operation.

The modulus and its root are fixed when the block is elaborated. The default is m = 13 with r = 5. The block computes the modular inverses of 2 and of r itself at elaboration time. Every result passes through one register stage, and a valid flag travels with the data. Operands are expected to be already reduced, that is, smaller than m.

Top module: `qr_complex_map`

## Requirements
- R1: While rst_n is low and after it rises, until the first accepted operation, out_valid is 0 and res_a and res_b are 0.
- R2: With inv_mode = 0 (forward), res_a equals (op_a + r·op_b) mod m. For m = 13 and r = 5, the input (0,1) gives 5.
- R3: With inv_mode = 0, res_b equals (op_a − r·op_b) mod m, which is the evaluation at the second root m − r. For the input (0,1) this gives 8.
- R4: With inv_mode = 1 (inverse), res_a equals 2⁻¹·(op_a + op_b) mod m.
- R5: With inv_mode = 1, res_b equals 2⁻¹·r⁻¹·(op_a − op_b) mod m. For m = 13 this uses 2⁻¹ = 7 and r⁻¹ = 8, so the input (5,8) gives (0,1).
- R6: The results of an operation accepted at a clock edge appear after exactly that edge. On every edge, out_valid takes the value in_valid had at that edge, so back-to-back operations stream out one per cycle.
- R7: An edge where in_valid is 0 leaves res_a and res_b unchanged, whatever op_a, op_b and inv_mode carry.
- R8: For every pair (a, b) modulo 13, a forward operation followed by an inverse operation on its two results returns (a, b).
- R9: res_a and res_b are always less than m.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands and mode are accepted on this edge |
| inv_mode | input | 1 | 0: forward map, 1: inverse map |
| op_a | input | ceil(log2 m) | Real part (forward) or first channel value (inverse) |
| op_b | input | ceil(log2 m) | Imaginary part (forward) or second channel value (inverse) |
| out_valid | output | 1 | Results are fresh this cycle |
| res_a | output | ceil(log2 m) | First channel value (forward) or real part (inverse) |
| res_b | output | ceil(log2 m) | Second channel value (forward) or imaginary part (inverse) |

## Verification
The bench sweeps all 169 operand pairs through a forward and then an inverse operation. A wrong inverse constant, or a wrong sign on the second root, breaks the recovery for almost every pair. The bench also aims at the subtraction that wraps, where the second channel value is larger than the first. A design that forgets to add m before reducing returns a wrapped, wrong imaginary part there. Idle cycles that carry changing operands would expose a result register that loads without a valid. Alternating modes back to back would catch a valid flag or a mode select that is one cycle out of step.

// File: rtl/qr_complex_map.sv
`timescale 1ns/1ps
module qr_complex_map #(
  parameter int M    = 13,
  parameter int ROOT = 5,
  localparam int W   = $clog2(M)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic         inv_mode,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  output logic         out_valid,
  output logic [W-1:0] res_a,
  output logic [W-1:0] res_b
);

  function automatic int inv_mod(int v);
    int found = 0;
    for (int i = 1; i < M; i++)
      if (((v * i) % M) == 1) found = i;
    return found;
  endfunction

  localparam int PW    = 2 * W + 2;
  localparam int NROOT = M - ROOT;
  localparam int INV2  = inv_mod(2);
  localparam int INVR  = inv_mod(ROOT);
  localparam int KIM   = (INV2 * INVR) % M;

  logic [PW-1:0] pa, pb, fwd_p, fwd_n, inv_s, inv_d;
  logic [W-1:0]  nxt_a, nxt_b;

  assign pa    = PW'(op_a);
  assign pb    = PW'(op_b);
  assign fwd_p = pa + PW'(ROOT) * pb;
  assign fwd_n = pa + PW'(NROOT) * pb;
  assign inv_s = PW'(INV2) * (pa + pb);
  assign inv_d = PW'(KIM) * (pa + PW'(M) - pb);

  assign nxt_a = inv_mode ? W'(inv_s % PW'(M)) : W'(fwd_p % PW'(M));
  assign nxt_b = inv_mode ? W'(inv_d % PW'(M)) : W'(fwd_n % PW'(M));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      res_a     <= '0;
      res_b     <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        res_a <= nxt_a;
        res_b <= nxt_b;
      end
    end
  end

endmodule

// File: rtl/qr_complex_map_chk.sv
`timescale 1ns/1ps
module qr_complex_map_chk #(
  parameter int M    = 13,
  parameter int ROOT = 5,
  parameter int W    = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         inv_mode,
  input logic [W-1:0] op_a,
  input logic [W-1:0] op_b,
  input logic         out_valid,
  input logic [W-1:0] res_a,
  input logic [W-1:0] res_b
);

  // R6
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(in_valid));

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(in_valid) |-> ($stable(res_a) && $stable(res_b)));

  // R9
  range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(res_a) < M) && (int'(res_b) < M));

  // R2 R3
  fwd_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !$past(inv_mode)) |->
      ((int'(res_a) + int'(res_b)) % M == (2 * int'($past(op_a))) % M));

  // R2 R3
  fwd_diff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !$past(inv_mode)) |->
      ((int'(res_a) + M - int'(res_b)) % M == (2 * ROOT * int'($past(op_b))) % M));

  // R4
  inv_real_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(inv_mode)) |->
      ((2 * int'(res_a)) % M == (int'($past(op_a)) + int'($past(op_b))) % M));

  // R5
  inv_imag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(inv_mode)) |->
      ((2 * ROOT * int'(res_b)) % M == (int'($past(op_a)) + M - int'($past(op_b))) % M));

endmodule

bind qr_complex_map qr_complex_map_chk #(.M(M), .ROOT(ROOT), .W(W)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .inv_mode(inv_mode),
  .op_a(op_a), .op_b(op_b), .out_valid(out_valid), .res_a(res_a), .res_b(res_b)
);

// File: tb/qr_complex_map_tb_top.sv
`timescale 1ns/1ps
module qr_complex_map_tb_top;
  localparam int M = 13;
  localparam int R = 5;
  localparam int W = $clog2(M);

  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0, inv_mode = 1'b0;
  logic [W-1:0] op_a = '0, op_b = '0;
  logic out_valid;
  logic [W-1:0] res_a, res_b;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  int m_a = 0, m_b = 0;
  bit m_v = 1'b0, m_inv = 1'b0;

  qr_complex_map #(.M(M), .ROOT(R)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .inv_mode(inv_mode),
    .op_a(op_a), .op_b(op_b), .out_valid(out_valid), .res_a(res_a), .res_b(res_b)
  );

  always #2.5 clk = ~clk;

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic void model_fwd(int a, int b, output int x, output int y);
    x = (a + R * b) % M;
    y = (((a - R * b) % M) + M) % M;
  endfunction

  function automatic void model_inv(int ca, int cb, output int x, output int y);
    x = 0; y = 0;
    for (int i = 0; i < M; i++)
      for (int j = 0; j < M; j++) begin
        int p, q;
        model_fwd(i, j, p, q);
        if (p == ca && q == cb) begin x = i; y = j; end
      end
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_v = 1'b0; m_a = 0; m_b = 0;
    end else begin
      m_v = in_valid;
      if (in_valid) begin
        m_inv = inv_mode;
        if (inv_mode) model_inv(int'(op_a), int'(op_b), m_a, m_b);
        else          model_fwd(int'(op_a), int'(op_b), m_a, m_b);
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(out_valid == m_v, "R6", int'(out_valid), int'(m_v));
      chk(int'(res_a) == m_a, m_inv ? "R4" : "R2", int'(res_a), m_a);
      chk(int'(res_b) == m_b, m_inv ? "R5" : "R3", int'(res_b), m_b);
      chk(int'(res_a) < M && int'(res_b) < M, "R9", int'(res_a) > int'(res_b) ? int'(res_a) : int'(res_b), M - 1);
    end
  end

  task automatic drive(bit v, bit inv, int a, int b);
    @(negedge clk);
    in_valid = v; inv_mode = inv; op_a = W'(a); op_b = W'(b);
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL R6 watchdog expired actual %0d expected %0d", 0, 1);
    summary();
    $finish;
  end

  initial begin
    int x, y;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(out_valid == 1'b0, "R1", int'(out_valid), 0);
    chk(res_a == '0 && res_b == '0, "R1", int'(res_a) + int'(res_b), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0 && res_a == '0, "R1", int'(res_a), 0);

    // R2 R3 forward on (0,1)
    drive(1, 0, 0, 1);
    drive(0, 0, 0, 0);
    chk(res_a == 4'd5, "R2", int'(res_a), 5);
    chk(res_b == 4'd8, "R3", int'(res_b), 8);

    // R7 idle cycles with moving operands and mode
    drive(0, 1, 11, 3);
    drive(0, 0, 7, 12);
    drive(0, 1, 2, 9);
    chk(res_a == 4'd5 && res_b == 4'd8, "R7", int'(res_a) * 16 + int'(res_b), 5 * 16 + 8);
    chk(out_valid == 1'b0, "R7", int'(out_valid), 0);

    // R4 R5 inverse on (5,8) -> (0,1)
    drive(1, 1, 5, 8);
    drive(0, 0, 0, 0);
    chk(res_a == '0, "R4", int'(res_a), 0);
    chk(res_b == 4'd1, "R5", int'(res_b), 1);

    // R5 wrapping subtraction: channels (1,12) -> aI = 7*8*(1-12) mod 13
    drive(1, 1, 1, 12);
    drive(0, 0, 0, 0);
    chk(int'(res_b) == (((56 * (1 - 12)) % M) + M) % M, "R5", int'(res_b), (((56 * (1 - 12)) % M) + M) % M);

    // R6 back-to-back alternating modes, checked every clock by the model
    for (int k = 0; k < 20; k++) drive(1, k[0], (k * 7) % M, (k * 5 + 3) % M);
    drive(0, 0, 0, 0);
    drive(1, 0, 12, 12);
    drive(1, 1, 12, 0);
    drive(0, 0, 0, 0);

    // R8 round trip over every pair
    for (int a = 0; a < M; a++)
      for (int b = 0; b < M; b++) begin
        drive(1, 0, a, b);
        @(negedge clk);
        x = int'(res_a); y = int'(res_b);
        in_valid = 1'b1; inv_mode = 1'b1; op_a = W'(x); op_b = W'(y);
        @(negedge clk);
        chk(int'(res_a) == a, "R8", int'(res_a), a);
        chk(int'(res_b) == b, "R8", int'(res_b), b);
        in_valid = 1'b0;
      end

    drive(0, 0, 0, 0);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule